// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds wall-clock time and calendar date as packed BCD bytes and moves them forward by one second each time a one-second strobe arrives. The fields are seconds, minutes, hours, weekday, day of month, month and a two-digit year. The hour byte can use a 24-hour encoding or a 12-hour encoding with a meridiem flag. Month lengths and February in leap years are handled in hardware, so software only loads a starting point.

Software sets the time through a byte-wide write port and reads it back through a combinational read port. Bit 7 of the seconds byte is a run control. The current fields are also driven out on dedicated ports, along with a leap-year flag. Writes are stored exactly as given, with no range checking.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, seconds, minutes and hours are 00 in 24-hour format, weekday is 1, date, month and year are 01, and the run bit is 0.
- R2: The run bit is bit 7 of the byte at address 0. While it is 0, ticks are ignored and every time field holds its value. While it is 1, each tick advances the time by one second.
- R3: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count packed BCD 00 to 59. Seconds wrap from 59 to 00 and advance minutes. Minutes wrap from 59 to 00 and advance the hour.
- R4: The hour byte is at address 2. Bit 6 = 0 selects 24-hour format, where bits 5:0 count BCD 00 to 23 and the wrap from 23 to 00 advances the day. A tick never changes bit 6.
- R5: With bit 6 = 1, bit 5 is the PM flag (1 = PM), bit 4 is the tens digit and bits 3:0 are the units. 11 goes to 12 with PM toggled, 12 goes to 01 with PM unchanged, and only the step from 11 PM to 12 AM advances the day.
- R6: Weekday (address 3, bits 2:0) counts 1 to 7 and goes from 7 to 1 on each day advance.
- R7: Date (address 4, bits 5:0) counts from 01 to the month's last day: 30 for months 04, 06, 09 and 11, 29 or 28 for 02 depending on the leap flag, and 31 for the others. It then goes back to 01 and advances the month (address 5, bits 4:0). Month goes from 12 to 01 and advances the year (address 6, BCD 00 to 99). Year 99 wraps to 00.
- R8: The leap flag is 1 exactly when the year's numeric value is divisible by 4, with 00 counted as a leap year. It is read as bit 5 of address 5 and driven on `leap_o`. Writes cannot alter it.
- R9: A write to addresses 0 to 6 stores the value without any validity check. Bits a field does not implement read as 0. Address 7 reads 0, and writes to it change nothing.
- R10: If a write and a tick arrive in the same cycle, the write is applied and that tick is discarded entirely.
- R11: `rd_data` shows the byte selected by `rd_addr` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 7 | Hour byte with format and PM bits |
| wday_o | output | 3 | Weekday 1..7 |
| date_o | output | 6 | Day of month, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| leap_o | output | 1 | Leap-year flag |

## Verification
The hardest cases are cascades in which one tick ripples through every field: year 99 rolling to 00, February 29 in a leap year, and 11 PM rolling to 12 AM in 12-hour mode. From the ports alone these would take days of simulated seconds to reach. The stimulus therefore loads each field to one second before the boundary, loops over every month in leap and non-leap years in both hour formats, and then lets a behavioural reference model track every cycle. Writes that land in the same cycle as a tick are driven on purpose to show the tick being dropped.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 7;
    localparam int WDAY_W = 3;
    localparam int DATE_W = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 8;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_WDAY = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

    typedef struct packed {
        logic              run;
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [WDAY_W-1:0] wday;
        logic [DATE_W-1:0] date;
        logic [MON_W-1:0]  mon;
        logic [YEAR_W-1:0] year;
    } cal_t;

    localparam cal_t CAL_RST = '{
        run:  1'b0,
        sec:  7'h00,
        min:  7'h00,
        hour: 7'h00,
        wday: 3'd1,
        date: 6'h01,
        mon:  5'h01,
        year: 8'h01
    };

    // value mod 4 equals (units + 2*tens) mod 4 for a two-digit BCD year
    function automatic logic leap_of(input logic [YEAR_W-1:0] y);
        logic [1:0] s;
        s = y[1:0] + {y[4], 1'b0};
        return (s == 2'd0);
    endfunction

endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
    parameter int W = 7
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] top,
    input  logic [W-1:0] base,
    output logic [W-1:0] nxt,
    output logic         wrap
);

    generate
        if (W > 4) begin : g_two_digit
            localparam int TW = W - 4;
            always_comb begin
                wrap = (cur == top);
                if (wrap)
                    nxt = base;
                else if (cur[3:0] == 4'h9)
                    nxt = {cur[W-1:4] + TW'(1), 4'h0};
                else
                    nxt = {cur[W-1:4], cur[3:0] + 4'h1};
            end
        end else begin : g_one_digit
            always_comb begin
                wrap = (cur == top);
                nxt  = wrap ? base : cur + W'(1);
            end
        end
    endgenerate

endmodule

// File: rtl/hour_step.sv
module hour_step #(
    parameter int W = 7
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         day_carry
);

    logic mode12;
    assign mode12 = cur[6];

    always_comb begin
        nxt       = cur;
        day_carry = 1'b0;
        if (!mode12) begin
            if (cur[5:0] == 6'h23) begin
                nxt       = '0;
                day_carry = 1'b1;
            end else if (cur[3:0] == 4'h9) begin
                nxt = {1'b0, cur[5:4] + 2'd1, 4'h0};
            end else begin
                nxt = {cur[6:4], cur[3:0] + 4'h1};
            end
        end else begin
            if (cur[4:0] == 5'h12) begin
                nxt = {cur[6:5], 5'h01};
            end else if (cur[4:0] == 5'h11) begin
                nxt       = {1'b1, ~cur[5], 5'h12};
                day_carry = cur[5];
            end else if (cur[3:0] == 4'h9) begin
                nxt = {cur[6:5], 1'b1, 4'h0};
            end else begin
                nxt = {cur[6:4], cur[3:0] + 4'h1};
            end
        end
    end

endmodule

// File: rtl/month_last.sv
module month_last #(
    parameter int MW = 5,
    parameter int DW = 6
) (
    input  logic [MW-1:0] mon,
    input  logic          leap,
    output logic [DW-1:0] last
);

    always_comb begin
        case (mon)
            5'h02:                      last = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last = 6'h30;
            default:                    last = 6'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcdcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  sec_o,
    output logic [MIN_W-1:0]  min_o,
    output logic [HOUR_W-1:0] hour_o,
    output logic [WDAY_W-1:0] wday_o,
    output logic [DATE_W-1:0] date_o,
    output logic [MON_W-1:0]  month_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              leap_o
);

    cal_t st_q, st_d;

    logic [SEC_W-1:0]  sec_nx;
    logic [MIN_W-1:0]  min_nx;
    logic [HOUR_W-1:0] hour_nx;
    logic [WDAY_W-1:0] wday_nx;
    logic [DATE_W-1:0] date_nx, date_top;
    logic [MON_W-1:0]  mon_nx;
    logic [YEAR_W-1:0] year_nx;
    logic sec_wr, min_wr, day_c, wday_wr, date_wr, mon_wr, year_wr;
    logic leap_now;

    assign leap_now = leap_of(st_q.year);

    bcd_step #(.W(SEC_W)) u_sec (
        .cur(st_q.sec), .top(7'h59), .base(7'h00), .nxt(sec_nx), .wrap(sec_wr));
    bcd_step #(.W(MIN_W)) u_min (
        .cur(st_q.min), .top(7'h59), .base(7'h00), .nxt(min_nx), .wrap(min_wr));
    hour_step #(.W(HOUR_W)) u_hour (
        .cur(st_q.hour), .nxt(hour_nx), .day_carry(day_c));
    bcd_step #(.W(WDAY_W)) u_wday (
        .cur(st_q.wday), .top(3'd7), .base(3'd1), .nxt(wday_nx), .wrap(wday_wr));
    month_last #(.MW(MON_W), .DW(DATE_W)) u_mlast (
        .mon(st_q.mon), .leap(leap_now), .last(date_top));
    bcd_step #(.W(DATE_W)) u_date (
        .cur(st_q.date), .top(date_top), .base(6'h01), .nxt(date_nx), .wrap(date_wr));
    bcd_step #(.W(MON_W)) u_mon (
        .cur(st_q.mon), .top(5'h12), .base(5'h01), .nxt(mon_nx), .wrap(mon_wr));
    bcd_step #(.W(YEAR_W)) u_year (
        .cur(st_q.year), .top(8'h99), .base(8'h00), .nxt(year_nx), .wrap(year_wr));

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_SEC:  begin
                    st_d.run = wr_data[7];
                    st_d.sec = wr_data[SEC_W-1:0];
                end
                A_MIN:  st_d.min  = wr_data[MIN_W-1:0];
                A_HOUR: st_d.hour = wr_data[HOUR_W-1:0];
                A_WDAY: st_d.wday = wr_data[WDAY_W-1:0];
                A_DATE: st_d.date = wr_data[DATE_W-1:0];
                A_MON:  st_d.mon  = wr_data[MON_W-1:0];
                A_YEAR: st_d.year = wr_data[YEAR_W-1:0];
                default: ;
            endcase
        end else if (tick && st_q.run) begin
            st_d.sec = sec_nx;
            if (sec_wr) begin
                st_d.min = min_nx;
                if (min_wr) begin
                    st_d.hour = hour_nx;
                    if (day_c) begin
                        st_d.wday = wday_nx;
                        st_d.date = date_nx;
                        if (date_wr) begin
                            st_d.mon = mon_nx;
                            if (mon_wr)
                                st_d.year = year_nx;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAL_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = {st_q.run, st_q.sec};
            A_MIN:   rd_data = {1'b0, st_q.min};
            A_HOUR:  rd_data = {1'b0, st_q.hour};
            A_WDAY:  rd_data = {5'b0, st_q.wday};
            A_DATE:  rd_data = {2'b0, st_q.date};
            A_MON:   rd_data = {2'b0, leap_now, st_q.mon};
            A_YEAR:  rd_data = st_q.year;
            default: rd_data = '0;
        endcase
    end

    assign sec_o   = st_q.sec;
    assign min_o   = st_q.min;
    assign hour_o  = st_q.hour;
    assign wday_o  = st_q.wday;
    assign date_o  = st_q.date;
    assign month_o = st_q.mon;
    assign year_o  = st_q.year;
    assign leap_o  = leap_now;

    // R2: halted counters hold every field
    a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && rd_addr == A_SEC && !wr_en)
        |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));

    // R3: seconds roll over from 59 to 00 on an accepted tick
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.run && sec_o == 7'h59) |=> (sec_o == 7'h00));

    // R4: ticking never alters the hour format bit
    a_r4_format_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hour_o[6]));

    // R5: 11:59:59 AM in 12-hour mode steps to 12 PM
    a_r5_noon_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.run && sec_o == 7'h59 && min_o == 7'h59
         && hour_o == 7'h51) |=> (hour_o == 7'h72));

    // R8: the leap flag only moves when the year moves
    a_r8_leap_with_year: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(leap_o) |-> !$stable(year_o));

    // R10: a write in a tick cycle lands and the seconds do not also step
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tick && wr_addr == A_SEC) |=> (sec_o == $past(wr_data[6:0])));

endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [6:0] sec_o, min_o, hour_o;
    logic [2:0] wday_o;
    logic [5:0] date_o;
    logic [4:0] month_o;
    logic [7:0] year_o;
    logic       leap_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcd_calendar u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sec_o(sec_o),
        .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .leap_o(leap_o));

    // ---------------- reference model (binary integers) ----------------
    int m_run, m_s, m_mi, m_fmt, m_h, m_pm, m_wd, m_d, m_mo, m_y;

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction
    function automatic int from_bcd(int b);
        return ((b >> 4) * 10) + (b & 15);
    endfunction
    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic int exp_hour();
        if (m_fmt != 0) return 'h40 | (m_pm << 5) | to_bcd(m_h);
        return to_bcd(m_h);
    endfunction
    function automatic int exp_read(int a);
        case (a)
            0: return (m_run << 7) | to_bcd(m_s);
            1: return to_bcd(m_mi);
            2: return exp_hour();
            3: return m_wd;
            4: return to_bcd(m_d);
            5: return to_bcd(m_mo) | (((m_y % 4) == 0 ? 1 : 0) << 5);
            6: return to_bcd(m_y);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_s = 0; m_mi = 0; m_fmt = 0; m_h = 0; m_pm = 0;
            m_wd = 1; m_d = 1; m_mo = 1; m_y = 1;
        end else if (wr_en) begin
            case (int'(wr_addr))
                0: begin m_run = wr_data[7]; m_s = from_bcd(wr_data & 8'h7f); end
                1: m_mi = from_bcd(wr_data & 8'h7f);
                2: begin
                    m_fmt = wr_data[6];
                    if (wr_data[6]) begin m_pm = wr_data[5]; m_h = from_bcd(wr_data & 8'h1f); end
                    else begin m_pm = 0; m_h = from_bcd(wr_data & 8'h3f); end
                end
                3: m_wd = wr_data & 8'h07;
                4: m_d = from_bcd(wr_data & 8'h3f);
                5: m_mo = from_bcd(wr_data & 8'h1f);
                6: m_y = from_bcd(wr_data);
                default: ;
            endcase
        end else if (tick && m_run != 0) begin
            if (m_s != 59) m_s++;
            else begin
                m_s = 0;
                if (m_mi != 59) m_mi++;
                else begin
                    bit dc;
                    m_mi = 0;
                    dc = 0;
                    if (m_fmt == 0) begin
                        if (m_h == 23) begin m_h = 0; dc = 1; end else m_h++;
                    end else begin
                        if (m_h == 11) begin m_h = 12; dc = (m_pm != 0); m_pm = 1 - m_pm; end
                        else if (m_h == 12) m_h = 1;
                        else m_h++;
                    end
                    if (dc) begin
                        m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                        if (m_d == days_in(m_mo, m_y)) begin
                            m_d = 1;
                            if (m_mo == 12) begin
                                m_mo = 1;
                                m_y = (m_y == 99) ? 0 : m_y + 1;
                            end else m_mo++;
                        end else m_d++;
                    end
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            check("R3 seconds", int'(sec_o), to_bcd(m_s));
            check("R3 minutes", int'(min_o), to_bcd(m_mi));
            check("R4/R5 hour", int'(hour_o), exp_hour());
            check("R6 weekday", int'(wday_o), m_wd);
            check("R7 date", int'(date_o), to_bcd(m_d));
            check("R7 month", int'(month_o), to_bcd(m_mo));
            check("R7 year", int'(year_o), to_bcd(m_y));
            check("R8 leap", int'(leap_o), (m_y % 4 == 0) ? 1 : 0);
            check("R11 read", int'(rd_data), exp_read(int'(rd_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask
    task automatic wr_tick(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; tick = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask
    task automatic rd_chk(string tag, int a, int exp);
        @(negedge clk);
        rd_addr = 3'(a);
        #1;
        check(tag, int'(rd_data), exp);
    endtask
    task automatic set_eod(int hour_byte);
        wr(2, hour_byte); wr(1, 'h59); wr(0, 'hD9);
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 sec", int'(sec_o), 0);
        check("R1 hour", int'(hour_o), 0);
        check("R1 wday", int'(wday_o), 1);
        check("R1 date", int'(date_o), 1);
        check("R1 month", int'(month_o), 1);
        check("R1 year", int'(year_o), 1);
        rd_chk("R1 run bit clear", 0, 0);

        ticks(4);
        #1 check("R2 stopped seconds", int'(sec_o), 0);

        // century, year and weekday rollover in 24-hour mode
        wr(6, 'h99); wr(5, 'h12); wr(4, 'h31); wr(3, 7);
        wr(2, 'h23); wr(1, 'h59); wr(0, 'hD8);
        ticks(2);
        #1;
        check("R3 sec wrap", int'(sec_o), 0);
        check("R4 hour wrap", int'(hour_o), 0);
        check("R6 weekday wrap", int'(wday_o), 1);
        check("R7 new year", int'(date_o) << 16 | int'(month_o) << 8 | int'(year_o), 'h010100);
        check("R8 year 00 is leap", int'(leap_o), 1);
        rd_chk("R11 read seconds with run", 0, 'h80);

        // 12-hour transitions
        set_eod('h51); ticks(1);
        #1 check("R5 11AM to 12PM", int'(hour_o), 'h72);
        set_eod('h72); ticks(1);
        #1 check("R5 12PM to 1PM", int'(hour_o), 'h61);
        wr(3, 3);
        set_eod('h71); ticks(1);
        #1;
        check("R5 11PM to 12AM", int'(hour_o), 'h52);
        check("R6 weekday on midnight", int'(wday_o), 4);

        // month lengths
        wr(6, 'h24); wr(5, 'h02); wr(4, 'h28);
        set_eod('h23); ticks(1);
        #1 check("R7 Feb 29 leap", int'(date_o), 'h29);
        set_eod('h23); ticks(1);
        #1 check("R7 leap Feb to Mar", int'(month_o) << 8 | int'(date_o), 'h0301);
        wr(6, 'h23); wr(5, 'h02); wr(4, 'h28);
        set_eod('h23); ticks(1);
        #1 check("R7 common Feb to Mar", int'(month_o) << 8 | int'(date_o), 'h0301);
        rd_chk("R8 leap bit clear in 23", 5, 'h03);

        // write beats tick
        wr(0, 'hD9);
        wr_tick(1, 'h10);
        #1;
        check("R10 tick dropped", int'(sec_o), 'h59);
        check("R10 write applied", int'(min_o), 'h10);
        wr_tick(0, 'hA0);
        #1 check("R10 sec write wins", int'(sec_o), 'h20);

        // raw writes and ignored bits
        wr(0, 'h00);
        wr(1, 'h75);
        #1 check("R9 unchecked minutes", int'(min_o), 'h75);
        wr(5, 'h25);
        rd_chk("R9 leap bit not writable", 5, 'h05);
        wr(7, 'hFF);
        #1 check("R9 addr7 write ignored", int'(min_o) << 8 | int'(month_o), 'h7505);
        rd_chk("R9 addr7 reads zero", 7, 0);
        rd_chk("R9 weekday upper bits zero", 3, int'(wday_o));
        ticks(3);
        #1 check("R2 halted after stop", int'(sec_o), 0);

        // sweep every month end, both formats, leap and common years
        for (int f = 0; f < 2; f++) begin
            for (int yi = 0; yi < 3; yi++) begin
                for (int mo = 1; mo <= 12; mo++) begin
                    int yv;
                    yv = (yi == 0) ? 0 : (yi == 1) ? 1 : 96;
                    wr(6, to_bcd(yv)); wr(5, to_bcd(mo));
                    wr(4, to_bcd(days_in(mo, yv)));
                    wr(2, f ? 'h71 : 'h23); wr(1, 'h59); wr(0, 'hD0);
                    ticks(12);
                    #1 check("R7 month end sweep", int'(date_o), 1);
                end
            end
        end

        // free run with irregular ticks, model compared every clock
        wr(2, 'h49); wr(1, 'h30); wr(0, 'h80);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tick = ((i % 3) != 1);
            rd_addr = 3'(i % 8);
        end
        @(negedge clk); tick = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule